// File: doc/BRIEF.md
# Triple Timer Register Interface

This block is the software-visible register bank that sits in front of three independent timer channels. A single 4 KB window is reached through a plain valid/write/address/data bus carrying 32-bit words. Registers of the same kind are interleaved across the channels. The word index divided by three selects the register kind, and the word index modulo three selects the channel.

For each channel the bank holds:
- the clock-control setting,
- the counter-control setting,
- the interval limit,
- three match values,
- the interrupt enables,
- the event-control setting.

It drives all of these to a per-channel counter core. The count and the event measurement come back from the core as inputs and are readable but not writable. Each core raises single-cycle event pulses. The bank gathers them into a sticky status word that clears when software reads it. Each channel drives one registered, level-sensitive interrupt. A read returns data on `bus_rdata` one clock after the request cycle.

Top module: `tri_timer_regs`

## Requirements
- R1: For byte address A, word index W = A/4 selects register kind W/3 and channel W mod 3. The kinds are, in order: 0 clock control, 1 counter control, 2 count value, 3 interval, 4..6 match 0..2, 7 interrupt status, 8 interrupt enable, 9 event control, 10 event value. For example, 0x04 is the clock control of channel 1 and 0x74 is the event control of channel 2.
- R2: After reset, counter control reads 0x21 on every channel. All other stored registers, the status words, the interrupts and the counter-reset pulses are zero.
- R3: Writes keep only part of the data word:
  - clock control and interrupt enable keep bits [5:0];
  - event control keeps bits [2:0];
  - interval and match registers keep bits [15:0].
  Reads return the kept bits, zero-extended.
- R4: Count value and event value reads return the channel's 16-bit core input, zero-extended. Writes to these kinds change nothing.
- R5: Reads of word indices 33 and above (byte offset 0x84 and up) return zero. Writes to those indices change no register.
- R6: Status bits are set by the channel's event input and stay set until read. The bit assignments are: bit 0 interval, bits 1..3 match 0..2, bit 4 overflow, bit 5 event overflow.
- R7: A status read returns the accumulated bits and clears them. An event pulse in the same cycle as the read is kept set and appears in the next read.
- R8: Writes to the interrupt status register have no effect.
- R9: A channel's interrupt output is high exactly when (status AND enable) is nonzero. It changes on the same edge as the state that causes it.
- R10: A write to match register k of channel c changes only that register. The other two match registers of c and all match registers of other channels keep their values.
- R11: A counter-control write stores data bits [5:0] with bit 4 forced to zero and drives the result to the core. When data bit 4 is set, that channel's counter-reset output pulses high for exactly one cycle after the write edge.
- R12: Read data is registered. It appears one cycle after the request and is zero in cycles that follow no read.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst | input | 1 | Synchronous active-high reset |
| bus_valid | input | 1 | Access request this cycle |
| bus_write | input | 1 | 1 = write, 0 = read |
| bus_addr | input | 12 | Byte address inside the window |
| bus_wdata | input | 32 | Write data |
| bus_rdata | output | 32 | Read data, one cycle after the request |
| count_i | input | 48 | Live 16-bit count per channel, channel c at [16c+15:16c] |
| evtval_i | input | 48 | 16-bit event measurement per channel |
| evt_i | input | 18 | Per-channel 6-bit event pulses, layout as R6 |
| clk_ctrl_o | output | 18 | Per-channel clock-control setting |
| cnt_ctrl_o | output | 18 | Per-channel counter-control setting, bit 4 always zero |
| cnt_rst_o | output | 3 | Per-channel counter-reset pulse |
| interval_o | output | 48 | Per-channel interval limit |
| match_o | output | 144 | Match values, channel c match k at [48c+16k+15 : 48c+16k] |
| evt_ctrl_o | output | 9 | Per-channel event-control setting |
| irq_o | output | 3 | Per-channel level interrupt |

## Verification
The hardest case to reach from the ports is a status read that lands in the same cycle as a fresh event pulse on that channel. A late pulse must survive the clear, while the read returns only the bits that came before it. The bench drives the read request and the event input on the same falling edge. It checks that the returned word excludes the new bit, then reads again to find it. Cross-channel isolation through the modulo-3 decode is reached by writing and reading the middle and last words of each register group and checking that the neighbouring channels' outputs stay unchanged.

// File: rtl/tri_timer_pkg.sv
package tri_timer_pkg;
  localparam int CTL_W   = 6;  // clock and counter control width
  localparam int EVC_W   = 3;  // event control width
  localparam int ST_W    = 6;  // status / enable width
  localparam int NMATCH  = 3;
  localparam int GRP_W   = 4;
  localparam int NGRP    = 11;
  localparam int RST_BIT = 4;  // counter-control reset request bit

  typedef enum logic [GRP_W-1:0] {
    G_CLK = 4'd0, G_CTL = 4'd1, G_CNT = 4'd2, G_IVL = 4'd3,
    G_MT0 = 4'd4, G_MT1 = 4'd5, G_MT2 = 4'd6, G_STS = 4'd7,
    G_IEN = 4'd8, G_EVC = 4'd9, G_EVV = 4'd10
  } grp_e;
endpackage

// File: rtl/tri_timer_decode.sv
module tri_timer_decode
  import tri_timer_pkg::*;
#(
  parameter int ADDR_W = 12,
  parameter int NUM_CH = 3
) (
  input  logic [ADDR_W-1:0] addr,
  output grp_e              grp,
  output logic [NUM_CH-1:0] sel,
  output logic              hit
);
  localparam int WORD_W = ADDR_W - 2;

  logic [WORD_W-1:0] word, quo, rem;

  always_comb begin
    word = addr[ADDR_W-1:2];
    quo  = word / WORD_W'(NUM_CH);
    rem  = word % WORD_W'(NUM_CH);
    hit  = word < WORD_W'(NGRP * NUM_CH);
    grp  = grp_e'(quo[GRP_W-1:0]);
  end

  for (genvar c = 0; c < NUM_CH; c++) begin : g_sel
    assign sel[c] = hit && (rem == WORD_W'(c));
  end

  // R1
  always_comb begin
    one_sel_chk : assert ($onehot0(sel));
  end
endmodule

// File: rtl/tri_timer_chan.sv
module tri_timer_chan
  import tri_timer_pkg::*;
#(
  parameter int DATA_W = 32,
  parameter int CNT_W  = 16
) (
  input  logic                     clk,
  input  logic                     rst,
  input  logic                     wr,
  input  logic                     rd,
  input  grp_e                     grp,
  input  logic [DATA_W-1:0]        wdata,
  input  logic [CNT_W-1:0]         count_i,
  input  logic [CNT_W-1:0]         evtval_i,
  input  logic [ST_W-1:0]          evt_i,
  output logic [DATA_W-1:0]        rdata,
  output logic [CTL_W-1:0]         clk_ctrl,
  output logic [CTL_W-1:0]         cnt_ctrl,
  output logic                     cnt_rst,
  output logic [CNT_W-1:0]         interval,
  output logic [NMATCH*CNT_W-1:0]  match,
  output logic [EVC_W-1:0]         evt_ctrl,
  output logic                     irq
);
  localparam logic [CTL_W-1:0] CTL_RESET = CTL_W'(6'h21);
  localparam logic [CTL_W-1:0] CTL_KEEP  = ~(CTL_W'(1) << RST_BIT);

  logic [CTL_W-1:0] clk_q, ctl_q;
  logic [CNT_W-1:0] ivl_q;
  logic [ST_W-1:0]  ien_q, stat_q, stat_d, ien_d;
  logic [EVC_W-1:0] evc_q;
  logic             irq_q, rst_q, stat_rd;
  logic [CNT_W-1:0] match_q [NMATCH];

  always_comb begin
    stat_rd = rd && (grp == G_STS);
    stat_d  = (stat_rd ? '0 : stat_q) | evt_i;
    ien_d   = (wr && grp == G_IEN) ? wdata[ST_W-1:0] : ien_q;
  end

  always_ff @(posedge clk) begin
    if (rst) begin
      clk_q  <= '0;
      ctl_q  <= CTL_RESET;
      ivl_q  <= '0;
      ien_q  <= '0;
      evc_q  <= '0;
      stat_q <= '0;
      irq_q  <= 1'b0;
      rst_q  <= 1'b0;
    end else begin
      stat_q <= stat_d;
      ien_q  <= ien_d;
      irq_q  <= |(stat_d & ien_d);
      rst_q  <= wr && (grp == G_CTL) && wdata[RST_BIT];
      if (wr) begin
        case (grp)
          G_CLK:   clk_q <= wdata[CTL_W-1:0];
          G_CTL:   ctl_q <= wdata[CTL_W-1:0] & CTL_KEEP;
          G_IVL:   ivl_q <= wdata[CNT_W-1:0];
          G_EVC:   evc_q <= wdata[EVC_W-1:0];
          default: ;
        endcase
      end
    end
  end

  for (genvar k = 0; k < NMATCH; k++) begin : g_match
    localparam logic [GRP_W-1:0] MK = GRP_W'(int'(G_MT0) + k);
    always_ff @(posedge clk) begin
      if (rst)
        match_q[k] <= '0;
      else if (wr && (grp == MK))
        match_q[k] <= wdata[CNT_W-1:0];
    end
    assign match[k*CNT_W +: CNT_W] = match_q[k];

    // R10
    match_hold_chk : assert property (@(posedge clk) disable iff (rst)
      !(wr && (grp == MK)) |=> $stable(match_q[k]));
  end

  always_comb begin
    rdata = '0;
    case (grp)
      G_CLK:   rdata[CTL_W-1:0] = clk_q;
      G_CTL:   rdata[CTL_W-1:0] = ctl_q;
      G_CNT:   rdata[CNT_W-1:0] = count_i;
      G_IVL:   rdata[CNT_W-1:0] = ivl_q;
      G_MT0:   rdata[CNT_W-1:0] = match_q[0];
      G_MT1:   rdata[CNT_W-1:0] = match_q[1];
      G_MT2:   rdata[CNT_W-1:0] = match_q[2];
      G_STS:   rdata[ST_W-1:0]  = stat_q;
      G_IEN:   rdata[ST_W-1:0]  = ien_q;
      G_EVC:   rdata[EVC_W-1:0] = evc_q;
      G_EVV:   rdata[CNT_W-1:0] = evtval_i;
      default: rdata = '0;
    endcase
  end

  assign clk_ctrl = clk_q;
  assign cnt_ctrl = ctl_q;
  assign cnt_rst  = rst_q;
  assign interval = ivl_q;
  assign evt_ctrl = evc_q;
  assign irq      = irq_q;

  // R7
  stat_clear_chk : assert property (@(posedge clk) disable iff (rst)
    stat_rd |=> (stat_q == $past(evt_i)));

  // R8
  stat_wr_ignored_chk : assert property (@(posedge clk) disable iff (rst)
    (wr && grp == G_STS && evt_i == '0) |=> (stat_q == $past(stat_q)));

  // R9
  irq_level_chk : assert property (@(posedge clk) disable iff (rst)
    irq_q == |(stat_q & ien_q));

  // R11
  rst_pulse_chk : assert property (@(posedge clk) disable iff (rst)
    rst_q |-> ($past(wr) && $past(grp == G_CTL) && !ctl_q[RST_BIT]));
endmodule

// File: rtl/tri_timer_regs.sv
module tri_timer_regs
  import tri_timer_pkg::*;
#(
  parameter int NUM_CH = 3,
  parameter int ADDR_W = 12,
  parameter int DATA_W = 32,
  parameter int CNT_W  = 16
) (
  input  logic                            clk,
  input  logic                            rst,
  input  logic                            bus_valid,
  input  logic                            bus_write,
  input  logic [ADDR_W-1:0]               bus_addr,
  input  logic [DATA_W-1:0]               bus_wdata,
  output logic [DATA_W-1:0]               bus_rdata,
  input  logic [NUM_CH*CNT_W-1:0]         count_i,
  input  logic [NUM_CH*CNT_W-1:0]         evtval_i,
  input  logic [NUM_CH*ST_W-1:0]          evt_i,
  output logic [NUM_CH*CTL_W-1:0]         clk_ctrl_o,
  output logic [NUM_CH*CTL_W-1:0]         cnt_ctrl_o,
  output logic [NUM_CH-1:0]               cnt_rst_o,
  output logic [NUM_CH*CNT_W-1:0]         interval_o,
  output logic [NUM_CH*NMATCH*CNT_W-1:0]  match_o,
  output logic [NUM_CH*EVC_W-1:0]         evt_ctrl_o,
  output logic [NUM_CH-1:0]               irq_o
);
  grp_e              grp;
  logic [NUM_CH-1:0] sel;
  logic              hit, rd_req;
  logic [DATA_W-1:0] ch_rdata [NUM_CH];
  logic [DATA_W-1:0] rd_mux, rdata_q;

  tri_timer_decode #(.ADDR_W(ADDR_W), .NUM_CH(NUM_CH)) i_decode (
    .addr(bus_addr), .grp(grp), .sel(sel), .hit(hit)
  );

  for (genvar c = 0; c < NUM_CH; c++) begin : g_ch
    tri_timer_chan #(.DATA_W(DATA_W), .CNT_W(CNT_W)) i_chan (
      .clk      (clk),
      .rst      (rst),
      .wr       (bus_valid && bus_write && sel[c]),
      .rd       (bus_valid && !bus_write && sel[c]),
      .grp      (grp),
      .wdata    (bus_wdata),
      .count_i  (count_i[c*CNT_W +: CNT_W]),
      .evtval_i (evtval_i[c*CNT_W +: CNT_W]),
      .evt_i    (evt_i[c*ST_W +: ST_W]),
      .rdata    (ch_rdata[c]),
      .clk_ctrl (clk_ctrl_o[c*CTL_W +: CTL_W]),
      .cnt_ctrl (cnt_ctrl_o[c*CTL_W +: CTL_W]),
      .cnt_rst  (cnt_rst_o[c]),
      .interval (interval_o[c*CNT_W +: CNT_W]),
      .match    (match_o[c*NMATCH*CNT_W +: NMATCH*CNT_W]),
      .evt_ctrl (evt_ctrl_o[c*EVC_W +: EVC_W]),
      .irq      (irq_o[c])
    );
  end

  always_comb begin
    rd_mux = '0;
    for (int c = 0; c < NUM_CH; c++)
      if (sel[c]) rd_mux = rd_mux | ch_rdata[c];
  end

  assign rd_req = bus_valid && !bus_write;

  always_ff @(posedge clk) begin
    if (rst)
      rdata_q <= '0;
    else
      rdata_q <= (rd_req && hit) ? rd_mux : '0;
  end

  assign bus_rdata = rdata_q;

  // R5
  unmapped_zero_chk : assert property (@(posedge clk) disable iff (rst)
    (rd_req && !hit) |=> (bus_rdata == '0));

  // R12
  idle_zero_chk : assert property (@(posedge clk) disable iff (rst)
    !rd_req |=> (bus_rdata == '0));
endmodule

// File: tb/test_tri_timer_regs.sv
`timescale 1ns/1ps
module test_tri_timer_regs;
  localparam int NCH = 3;

  logic         clk = 1'b0;
  logic         rst = 1'b1;
  logic         bus_valid = 1'b0, bus_write = 1'b0;
  logic [11:0]  bus_addr = '0;
  logic [31:0]  bus_wdata = '0;
  logic [31:0]  bus_rdata;
  logic [47:0]  count_i = '0, evtval_i = '0;
  logic [17:0]  evt_i = '0;
  logic [17:0]  clk_ctrl_o, cnt_ctrl_o;
  logic [2:0]   cnt_rst_o, irq_o;
  logic [47:0]  interval_o;
  logic [143:0] match_o;
  logic [8:0]   evt_ctrl_o;

  int checks = 0, errors = 0;
  logic done = 1'b0;

  always #2.5 clk = ~clk;

  tri_timer_regs i_tri_timer_regs (
    .clk(clk), .rst(rst), .bus_valid(bus_valid), .bus_write(bus_write),
    .bus_addr(bus_addr), .bus_wdata(bus_wdata), .bus_rdata(bus_rdata),
    .count_i(count_i), .evtval_i(evtval_i), .evt_i(evt_i),
    .clk_ctrl_o(clk_ctrl_o), .cnt_ctrl_o(cnt_ctrl_o), .cnt_rst_o(cnt_rst_o),
    .interval_o(interval_o), .match_o(match_o), .evt_ctrl_o(evt_ctrl_o),
    .irq_o(irq_o)
  );

  function automatic logic [11:0] adr(int grp, int ch);
    return 12'((grp * 3 + ch) * 4);
  endfunction

  task automatic check(string req, logic [31:0] got, logic [31:0] exp);
    checks++;
    if (got !== exp) begin
      errors++;
      $display("FAIL %s got %h expected %h", req, got, exp);
    end
  endtask

  task automatic wr(logic [11:0] a, logic [31:0] d);
    @(negedge clk);
    bus_valid = 1'b1; bus_write = 1'b1; bus_addr = a; bus_wdata = d;
    @(negedge clk);
    bus_valid = 1'b0; bus_write = 1'b0;
  endtask

  task automatic rd(logic [11:0] a, output logic [31:0] d);
    @(negedge clk);
    bus_valid = 1'b1; bus_write = 1'b0; bus_addr = a;
    @(negedge clk);
    bus_valid = 1'b0;
    d = bus_rdata;
  endtask

  task automatic pulse(int ch, logic [5:0] bits);
    @(negedge clk);
    evt_i[ch*6 +: 6] = bits;
    @(negedge clk);
    evt_i = '0;
  endtask

  task automatic t_reset();
    logic [31:0] d;
    for (int c = 0; c < NCH; c++)
      check("R2 cnt_ctrl reset", 32'(cnt_ctrl_o[c*6 +: 6]), 32'h21);
    check("R2 irq reset", 32'(irq_o), 0);
    check("R2 clk_ctrl reset", 32'(clk_ctrl_o), 0);
    check("R12 idle rdata", bus_rdata, 0);
    rd(adr(1, 1), d); check("R2 cnt_ctrl readback", d, 32'h21);
    rd(adr(7, 2), d); check("R2 status reset", d, 0);
  endtask

  task automatic t_interleave();
    logic [31:0] d;
    wr(12'h004, 32'h15);
    check("R1 clk ch1", 32'(clk_ctrl_o[6 +: 6]), 32'h15);
    check("R1 clk ch0/ch2 untouched", 32'({clk_ctrl_o[12 +: 6], clk_ctrl_o[0 +: 6]}), 0);
    wr(12'h074, 32'h5);
    check("R1 evt_ctrl ch2", 32'(evt_ctrl_o[6 +: 3]), 5);
    check("R1 evt_ctrl ch0/ch1", 32'(evt_ctrl_o[5:0]), 0);
    rd(12'h004, d); check("R1 clk readback ch1", d, 32'h15);
  endtask

  task automatic t_masking();
    logic [31:0] d;
    wr(adr(0, 2), 32'hFFFF_FFFF); rd(adr(0, 2), d); check("R3 clk mask", d, 32'h3F);
    wr(adr(8, 0), 32'hFFFF_FFC5); rd(adr(8, 0), d); check("R3 ien mask", d, 32'h05);
    wr(adr(9, 1), 32'hFFFF_FFFE); rd(adr(9, 1), d); check("R3 evc mask", d, 32'h06);
    wr(adr(3, 0), 32'hABCD_1234); rd(adr(3, 0), d); check("R3 interval mask", d, 32'h1234);
    check("R3 interval port", 32'(interval_o[15:0]), 32'h1234);
    wr(adr(8, 0), 32'h0);
  endtask

  task automatic t_readonly();
    logic [31:0] d;
    count_i[16 +: 16] = 16'hABCD;
    evtval_i[32 +: 16] = 16'h8001;
    wr(adr(2, 1), 32'h1111);
    rd(adr(2, 1), d); check("R4 count read", d, 32'hABCD);
    wr(adr(10, 2), 32'h2222);
    rd(adr(10, 2), d); check("R4 event value read", d, 32'h8001);
    check("R4 count write no effect on clk ch1", 32'(clk_ctrl_o[6 +: 6]), 32'h15);
  endtask

  task automatic t_unmapped();
    logic [31:0] d;
    rd(12'h084, d); check("R5 read 0x84", d, 0);
    rd(12'hFFC, d); check("R5 read 0xFFC", d, 0);
    wr(12'h084, 32'hFFFF_FFFF);
    check("R5 write ignored outputs", 32'({clk_ctrl_o, evt_ctrl_o}), 32'({6'h3F, 6'h15, 6'h0, 3'h5, 3'h6, 3'h0}));
    rd(adr(3, 0), d); check("R5 write ignored interval", d, 32'h1234);
  endtask

  task automatic t_status();
    logic [31:0] d;
    pulse(1, 6'h01);
    pulse(1, 6'h10);
    rd(adr(7, 1), d); check("R6 sticky interval+overflow", d, 32'h11);
    rd(adr(7, 1), d); check("R7 cleared after read", d, 0);
    pulse(0, 6'h20);
    wr(adr(7, 0), 32'h0);
    rd(adr(7, 0), d); check("R8 status write ignored", d, 32'h20);
  endtask

  task automatic t_clear_race();
    logic [31:0] d;
    pulse(2, 6'h02);
    @(negedge clk);
    bus_valid = 1'b1; bus_write = 1'b0; bus_addr = adr(7, 2);
    evt_i[12 +: 6] = 6'h08;
    @(negedge clk);
    bus_valid = 1'b0; evt_i = '0;
    check("R7 read returns prior bits", bus_rdata, 32'h02);
    rd(adr(7, 2), d); check("R7 concurrent event kept", d, 32'h08);
  endtask

  task automatic t_irq();
    logic [31:0] d;
    wr(adr(8, 2), 32'h08);
    pulse(2, 6'h02);
    check("R9 masked event no irq", 32'(irq_o), 0);
    pulse(2, 6'h08);
    check("R9 enabled event irq", 32'(irq_o), 32'h4);
    rd(adr(7, 2), d);
    check("R9 status readback", d, 32'h0A);
    check("R9 irq low after clear", 32'(irq_o), 0);
    pulse(2, 6'h08);
    wr(adr(8, 2), 32'h0);
    check("R9 irq low after disable", 32'(irq_o), 0);
    rd(adr(7, 2), d);
  endtask

  task automatic t_match();
    wr(adr(5, 1), 32'h9999_1234);
    check("R10 ch1 match1", 32'(match_o[48 + 16 +: 16]), 32'h1234);
    check("R10 ch1 match0/2", 32'({match_o[48 + 32 +: 16], match_o[48 +: 16]}), 0);
    check("R10 ch0/ch2 matches", 32'(|{match_o[143:96], match_o[47:0]}), 0);
  endtask

  task automatic t_cnt_ctrl();
    logic [31:0] d;
    @(negedge clk);
    bus_valid = 1'b1; bus_write = 1'b1; bus_addr = adr(1, 0); bus_wdata = 32'h3F;
    @(negedge clk);
    bus_valid = 1'b0; bus_write = 1'b0;
    check("R11 reset pulse high", 32'(cnt_rst_o), 32'h1);
    check("R11 stored ctrl", 32'(cnt_ctrl_o[0 +: 6]), 32'h2F);
    @(negedge clk);
    check("R11 reset pulse one cycle", 32'(cnt_rst_o), 0);
    wr(adr(1, 1), 32'h0C);
    check("R11 no pulse without bit4", 32'(cnt_rst_o), 0);
    rd(adr(1, 0), d); check("R11 readback", d, 32'h2F);
  endtask

  initial begin
    repeat (4) @(negedge clk);
    rst = 1'b0;
    @(negedge clk);
    t_reset();
    t_interleave();
    t_masking();
    t_readonly();
    t_unmapped();
    t_status();
    t_clear_race();
    t_irq();
    t_match();
    t_cnt_ctrl();
    repeat (2) @(negedge clk);
    check("R12 idle rdata after traffic", bus_rdata, 0);
    done = 1'b1;
    $display("CHECKS %0d ERRORS %0d", checks, errors);
    $finish;
  end

  initial begin
    repeat (20000) @(posedge clk);
    if (!done) begin
      checks++; errors++;
      $display("FAIL watchdog expired");
      $display("CHECKS %0d ERRORS %0d", checks, errors);
      $finish;
    end
  end
endmodule